// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block gives a host processor three byte-wide general purpose I/O ports, named A, B and C, behind a small register window. The host reaches it through an 8-bit data bus with active-low chip select, read and write strobes, and two address bits. Address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the control register. Port C is split into two independent nibbles, upper and lower, and each nibble has its own direction.

The control address takes two kinds of word, chosen by bit 7. With bit 7 set, the word configures direction and group modes for every port and clears all output latches. With bit 7 clear, the word sets or clears one port C pin and leaves the configuration alone. Only the basic mode is built. The handshake modes are accepted and stored in the group mode fields, but the ports keep to basic latched-output and direct-input behaviour. Every access completes in the cycle it is presented. The block never stalls the host, so the bus has no back-pressure. Pins are modelled as separate in, out and output-enable vectors, and the data bus is modelled the same way.

Top module: `ppi_port_unit`

## Requirements
- R1: While `rst` is high, and after it, every pin output-enable is 0, every output latch (`pa_out`, `pb_out`, `pc_out`) is 0, and both group modes are 0.
- R2: A write is taken on a rising clock edge where `cs_n`=0 and `wr_n`=0. Address 0 writes port A, 1 writes port B, 2 writes port C and 3 writes the control register. Reads use the same address map.
- R3: While `cs_n`=1, or while both strobes are high, nothing in the block changes.
- R4: A control word with bit 7=1 sets the port directions: bit 4 for port A, bit 3 for the C upper nibble, bit 1 for port B and bit 0 for the C lower nibble. A value of 1 means input and drives output-enable 0; a value of 0 means output and drives output-enable all ones for that port or nibble.
- R5: A control word with bit 7=1 also clears the A, B and C output latches to zero.
- R6: A value written to a port is held in its latch and shown on its `_out` pins from the next cycle. A read of a port set as output returns its latch.
- R7: A read of a port set as input returns the live `_in` pin value, with no latching.
- R8: A read of port C returns, per nibble, the latch if that nibble is an output and the pins if it is an input.
- R9: A control word with bit 7=0 writes bit 0 into the port C latch bit indexed by bits 3:1. Bits 6:4 are ignored. Directions and all other latch bits are unchanged.
- R10: Group A mode codes 01 and 1x, and group B mode code 1, are accepted in bits 6:5 and bit 2. The ports still behave as in basic mode, following their direction bits.
- R11: A read of the control address returns 0x00.
- R12: `d_oe` is 1 only while `cs_n`=0 and `rd_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| d_in | input | 8 | Host write data |
| d_out | output | 8 | Host read data |
| d_oe | output | 1 | Host data bus drive enable |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A latch |
| pa_oe | output | 8 | Port A drive enables |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B latch |
| pb_oe | output | 8 | Port B drive enables |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C latch |
| pc_oe | output | 8 | Port C drive enables, per nibble |

## Verification
The assertions assume that the host holds `cs_n` high while reset is active. They also assume that the strobes and address are stable across each clock edge, so that every control-word property sees exactly one intended write. The bench changes bus inputs one time unit after a rising edge and releases chip select after every single-cycle access. It never asserts read and write together, and it keeps reset and bus traffic apart.

// File: rtl/ppi_pkg.sv
package ppi_pkg;

  typedef enum logic [1:0] {
    SEL_A   = 2'd0,
    SEL_B   = 2'd1,
    SEL_C   = 2'd2,
    SEL_CTL = 2'd3
  } sel_e;

  typedef struct packed {
    logic [1:0] grpa_mode;
    logic       a_in;
    logic       cu_in;
    logic       grpb_mode;
    logic       b_in;
    logic       cl_in;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{grpa_mode: 2'b00, a_in: 1'b1, cu_in: 1'b1,
                                 grpb_mode: 1'b0, b_in: 1'b1, cl_in: 1'b1};

endpackage

// File: rtl/ppi_ctrl.sv
module ppi_ctrl
  import ppi_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [7:0]        wdata,
  output cfg_t              cfg,
  output logic              mode_load,
  output logic [PORT_W-1:0] bsr_mask,
  output logic [PORT_W-1:0] bsr_val
);
  localparam int IDX_W = $clog2(PORT_W);

  logic [IDX_W-1:0] bit_idx;

  assign mode_load = ctl_we && wdata[7];
  assign bit_idx   = wdata[IDX_W:1];

  always_comb begin
    bsr_mask = '0;
    if (ctl_we && !wdata[7]) bsr_mask[bit_idx] = 1'b1;
    bsr_val = {PORT_W{wdata[0]}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= CFG_RESET;
    end else if (mode_load) begin
      cfg.grpa_mode <= wdata[6:5];
      cfg.a_in      <= wdata[4];
      cfg.cu_in     <= wdata[3];
      cfg.grpb_mode <= wdata[2];
      cfg.b_in      <= wdata[1];
      cfg.cl_in     <= wdata[0];
    end
  end
endmodule

// File: rtl/ppi_latch.sv
module ppi_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] val,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else            q <= (q & ~mask) | (val & mask);
  end
endmodule

// File: rtl/ppi_rdmux.sv
module ppi_rdmux
  import ppi_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  sel_e              sel,
  input  cfg_t              cfg,
  input  logic [PORT_W-1:0] a_q,
  input  logic [PORT_W-1:0] a_pin,
  input  logic [PORT_W-1:0] b_q,
  input  logic [PORT_W-1:0] b_pin,
  input  logic [PORT_W-1:0] c_q,
  input  logic [PORT_W-1:0] c_pin,
  output logic [PORT_W-1:0] rdata
);
  localparam int HALF = PORT_W / 2;

  logic [PORT_W-1:0] c_view;

  assign c_view = {cfg.cu_in ? c_pin[PORT_W-1:HALF] : c_q[PORT_W-1:HALF],
                   cfg.cl_in ? c_pin[HALF-1:0]      : c_q[HALF-1:0]};

  always_comb begin
    unique case (sel)
      SEL_A:   rdata = cfg.a_in ? a_pin : a_q;
      SEL_B:   rdata = cfg.b_in ? b_pin : b_q;
      SEL_C:   rdata = c_view;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/ppi_port_unit.sv
module ppi_port_unit
  import ppi_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [7:0]        d_in,
  output logic [7:0]        d_out,
  output logic              d_oe,
  input  logic [PORT_W-1:0] pa_in,
  output logic [PORT_W-1:0] pa_out,
  output logic [PORT_W-1:0] pa_oe,
  input  logic [PORT_W-1:0] pb_in,
  output logic [PORT_W-1:0] pb_out,
  output logic [PORT_W-1:0] pb_oe,
  input  logic [PORT_W-1:0] pc_in,
  output logic [PORT_W-1:0] pc_out,
  output logic [PORT_W-1:0] pc_oe
);
  localparam int HALF = PORT_W / 2;

  sel_e              sel;
  logic              wr_act;
  cfg_t              cfg;
  logic              mode_load;
  logic [PORT_W-1:0] bsr_mask, bsr_val;
  logic [PORT_W-1:0] a_mask, b_mask, c_mask, c_val;
  logic [1:0]        c_half_in;

  assign sel    = sel_e'(addr);
  assign wr_act = !cs_n && !wr_n;

  ppi_ctrl #(.PORT_W(PORT_W)) u_ctrl (
    .clk(clk), .rst(rst), .ctl_we(wr_act && sel == SEL_CTL), .wdata(d_in),
    .cfg(cfg), .mode_load(mode_load), .bsr_mask(bsr_mask), .bsr_val(bsr_val)
  );

  assign a_mask = (wr_act && sel == SEL_A) ? '1 : '0;
  assign b_mask = (wr_act && sel == SEL_B) ? '1 : '0;
  assign c_mask = (wr_act && sel == SEL_C) ? '1 : bsr_mask;
  assign c_val  = (wr_act && sel == SEL_C) ? d_in[PORT_W-1:0] : bsr_val;

  ppi_latch #(.W(PORT_W)) u_lat_a (
    .clk(clk), .rst(rst), .clr(mode_load), .mask(a_mask), .val(d_in[PORT_W-1:0]), .q(pa_out)
  );
  ppi_latch #(.W(PORT_W)) u_lat_b (
    .clk(clk), .rst(rst), .clr(mode_load), .mask(b_mask), .val(d_in[PORT_W-1:0]), .q(pb_out)
  );

  assign c_half_in = {cfg.cu_in, cfg.cl_in};

  for (genvar h = 0; h < 2; h++) begin : g_chalf
    ppi_latch #(.W(HALF)) u_lat_c (
      .clk(clk), .rst(rst), .clr(mode_load),
      .mask(c_mask[h*HALF +: HALF]), .val(c_val[h*HALF +: HALF]),
      .q(pc_out[h*HALF +: HALF])
    );
    assign pc_oe[h*HALF +: HALF] = {HALF{!c_half_in[h]}};
  end

  assign pa_oe = {PORT_W{!cfg.a_in}};
  assign pb_oe = {PORT_W{!cfg.b_in}};

  ppi_rdmux #(.PORT_W(PORT_W)) u_rdmux (
    .sel(sel), .cfg(cfg),
    .a_q(pa_out), .a_pin(pa_in), .b_q(pb_out), .b_pin(pb_in),
    .c_q(pc_out), .c_pin(pc_in), .rdata(d_out)
  );

  assign d_oe = !cs_n && !rd_n;
endmodule

// File: rtl/ppi_port_unit_chk.sv
module ppi_port_unit_chk #(
  parameter int PORT_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic [1:0]        addr,
  input logic [7:0]        d_in,
  input logic [7:0]        d_out,
  input logic              d_oe,
  input logic [PORT_W-1:0] pa_out,
  input logic [PORT_W-1:0] pa_oe,
  input logic [PORT_W-1:0] pb_out,
  input logic [PORT_W-1:0] pb_oe,
  input logic [PORT_W-1:0] pc_out,
  input logic [PORT_W-1:0] pc_oe
);
  logic ctl_wr;
  assign ctl_wr = !cs_n && !wr_n && addr == 2'd3;

  p_mode_dir_r4: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && d_in[7]) |=> (pa_oe == {PORT_W{!$past(d_in[4])}}) &&
                            (pb_oe == {PORT_W{!$past(d_in[1])}}))
    else $error("p_mode_dir_r4");

  p_mode_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && d_in[7]) |=> (pa_out == '0 && pb_out == '0 && pc_out == '0))
    else $error("p_mode_clear_r5");

  p_bsr_bit_r9: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !d_in[7]) |=> (pc_out[$past(d_in[3:1])] == $past(d_in[0])) &&
                             $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe))
    else $error("p_bsr_bit_r9");

  p_no_select_r3: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
              $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)))
    else $error("p_no_select_r3");

  p_bus_idle_r12: assert property (@(posedge clk) disable iff (rst)
    (cs_n || rd_n) |-> !d_oe)
    else $error("p_bus_idle_r12");

  p_ctl_read_r11: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !rd_n && addr == 2'd3) |-> d_out == 8'h00)
    else $error("p_ctl_read_r11");
endmodule

bind ppi_port_unit ppi_port_unit_chk #(.PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
  .d_in(d_in), .d_out(d_out), .d_oe(d_oe),
  .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
  .pc_out(pc_out), .pc_oe(pc_oe)
);

// File: tb/test_ppi_port_unit.sv
module test_ppi_port_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] d_in = 8'h00;
  logic [7:0] d_out;
  logic       d_oe;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;
  exp_t sb_q[$];
  event rd_sample;

  always #4 clk = ~clk;

  ppi_port_unit i_ppi_port_unit (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .d_in(d_in), .d_out(d_out), .d_oe(d_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    addr = a; d_in = d; cs_n = 1'b0; wr_n = 1'b0;
    @(posedge clk); #1;
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_read(input logic [1:0] a, input logic [7:0] exp, input string tag);
    exp_t e;
    e.val = exp; e.tag = tag;
    sb_q.push_back(e);
    @(posedge clk); #1;
    addr = a; cs_n = 1'b0; rd_n = 1'b0;
    #2 -> rd_sample;
    @(posedge clk); #1;
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  // Monitor: pops the expected item for each read and compares the bus
  initial begin
    forever begin
      @(rd_sample);
      if (sb_q.size() == 0) begin
        check("scoreboard underflow", 8'h01, 8'h00);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.tag, " d_out"}, d_out, e.val);
        check("R12 d_oe during read", {7'd0, d_oe}, 8'h01);
      end
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    #2;
    // R1 reset state
    check("R1 pa_oe", pa_oe, 8'h00);
    check("R1 pb_oe", pb_oe, 8'h00);
    check("R1 pc_oe", pc_oe, 8'h00);
    check("R1 pa_out", pa_out, 8'h00);
    check("R1 pb_out", pb_out, 8'h00);
    check("R1 pc_out", pc_out, 8'h00);
    check("R12 idle d_oe", {7'd0, d_oe}, 8'h00);

    bus_read(2'd3, 8'h00, "R11 control read");

    // R4 all outputs
    bus_write(2'd3, 8'h80);
    #2;
    check("R4 pa_oe out", pa_oe, 8'hFF);
    check("R4 pb_oe out", pb_oe, 8'hFF);
    check("R4 pc_oe out", pc_oe, 8'hFF);

    // R2/R6 address map and latching
    bus_write(2'd0, 8'h5A);
    bus_write(2'd1, 8'hC3);
    bus_write(2'd2, 8'h96);
    #2;
    check("R2 pa_out", pa_out, 8'h5A);
    check("R2 pb_out", pb_out, 8'hC3);
    check("R2 pc_out", pc_out, 8'h96);
    bus_read(2'd0, 8'h5A, "R6 read A latch");
    bus_read(2'd1, 8'hC3, "R6 read B latch");
    bus_read(2'd2, 8'h96, "R6 read C latch");

    // R3 unselected write ignored
    @(posedge clk); #1;
    addr = 2'd0; d_in = 8'hFF; wr_n = 1'b0; cs_n = 1'b1;
    @(posedge clk); #1;
    wr_n = 1'b1;
    // selected but no strobe
    cs_n = 1'b0; addr = 2'd3; d_in = 8'h80;
    @(posedge clk); #1;
    cs_n = 1'b1;
    #2;
    check("R3 pa_out unchanged", pa_out, 8'h5A);
    check("R3 pc_out unchanged", pc_out, 8'h96);
    check("R12 d_oe no read", {7'd0, d_oe}, 8'h00);

    // R9 bit set/reset
    bus_write(2'd3, 8'h0E);     // clear pin 7
    #2 check("R9 clear pin7", pc_out, 8'h16);
    bus_write(2'd3, 8'h71);     // set pin 0, bits 6:4 junk
    #2 check("R9 set pin0", pc_out, 8'h17);
    check("R9 pa_oe kept", pa_oe, 8'hFF);
    check("R9 pc_oe kept", pc_oe, 8'hFF);
    check("R9 pa_out kept", pa_out, 8'h5A);

    // R5 mode word clears latches
    bus_write(2'd3, 8'h80);
    #2;
    check("R5 pa_out clear", pa_out, 8'h00);
    check("R5 pb_out clear", pb_out, 8'h00);
    check("R5 pc_out clear", pc_out, 8'h00);

    // R7/R8 mixed directions: A in, C upper in, B out, C lower out
    pa_in = 8'h3C; pc_in = 8'hA5; pb_in = 8'hEE;
    bus_write(2'd3, 8'h98);
    #2;
    check("R4 pa_oe in", pa_oe, 8'h00);
    check("R4 pc_oe split", pc_oe, 8'h0F);
    check("R4 pb_oe out", pb_oe, 8'hFF);
    bus_read(2'd0, 8'h3C, "R7 read A pins");
    pa_in = 8'h81;
    bus_read(2'd0, 8'h81, "R7 read A live pins");
    bus_write(2'd2, 8'h0B);
    bus_read(2'd2, 8'hAB, "R8 read C merged");
    bus_write(2'd1, 8'h42);
    bus_read(2'd1, 8'h42, "R6 read B out");

    // R10 handshake mode codes accepted, basic behaviour kept
    bus_write(2'd3, 8'hE4);
    #2;
    check("R10 pa_oe mode2", pa_oe, 8'hFF);
    check("R10 pb_oe mode1", pb_oe, 8'hFF);
    bus_write(2'd0, 8'h11);
    bus_read(2'd0, 8'h11, "R10 read A mode2");
    bus_write(2'd3, 8'hA2);
    #2 check("R10 pb_oe in", pb_oe, 8'h00);
    bus_read(2'd1, 8'hEE, "R10 read B pins");
    bus_read(2'd3, 8'h00, "R11 control read again");

    repeat (3) @(posedge clk);
    if (sb_q.size() != 0) check("scoreboard leftover", 8'(sb_q.size()), 8'h00);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        check("watchdog expired", 8'h01, 8'h00);
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule